// File: doc/BRIEF.md
# Write-protect and write-cycle controller

This block sits between a two-wire bus slave and a 256-byte nonvolatile array. It decides whether a committed page write may reach the array. It also times the internal programming cycle and reports it as busy. It holds a one-time lock flag that guards the lower half of the address space. Once set, only a reset that defines the flag's initial value clears it. The block also watches the external write-protect level, but only inside the window that opens when the slave captures bit D0 of the first data byte.

The slave drives the base address, byte count and the page bytes, then strobes a data commit or a lock commit at STOP. An accepted data commit starts a programming phase of a parameterised number of clocks. After that phase the surviving bytes leave one by one on a valid/ready write stream toward the array. If the protect level rises inside the window, the command is cancelled, or the running cycle is stopped at once. In both cases the block pulses an abort flag and returns to idle.

Top module: `wp_wcycle_ctrl`

## Requirements
- R1: The protect level is ignored before the first-data-bit strobe. If it is high on any clock from that strobe up to and including the commit, the commit starts no cycle, busy stays low, nothing is written and abort pulses for one clock.
- R2: An accepted data commit raises busy on the next clock. Busy then holds for WCYC_CLKS programming clocks, plus one clock per page byte while the array accepts every beat. Busy therefore lasts WCYC_CLKS plus the byte count. An accepted lock commit holds busy for exactly WCYC_CLKS clocks.
- R3: The protect level high on any busy clock drops busy on the next clock and pulses abort. After that no further byte is issued, and a lock cycle stopped this way leaves the lock flag clear.
- R4: A lock cycle that completes sets the lock flag, and the flag never falls afterwards. While it is set, no write is issued to an address whose most significant bit is 0. Addresses with that bit at 1 are still written.
- R5: A lock commit while the lock flag is already set is ignored: no busy, no abort.
- R6: Data or lock commits and first-data-bit strobes that arrive while busy are ignored and do not alter the running cycle.
- R7: No byte is issued while the low-supply flag is high. A lock cycle that ends with the low-supply flag high leaves the lock flag clear.
- R8: Page byte k (k from 0) is issued to the base address with its upper bits kept and its low 4 bits equal to the base's low 4 bits plus k, modulo 16. Bytes go out in ascending k. A byte count above 16 is clipped to 16.
- R9: On the write stream a beat transfers on a clock where valid and ready are both high. While valid is high and ready low, valid, address and data hold on the next clock, unless the protect level or the low-supply flag is high then.
- R10: After reset, busy, abort and write-valid are low and the lock flag equals the LOCK_INIT parameter (0 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_start_i | input | 1 | Data commit strobe (STOP after a write) |
| d0_cap_i | input | 1 | Strobe: D0 of the first data byte captured |
| lock_cmd_i | input | 1 | Lock commit strobe (STOP after a lock command) |
| page_addr_i | input | ADDR_W | Base byte address of the page write |
| page_cnt_i | input | CNT_W | Number of page bytes received |
| page_data_i | input | PAGE_BYTES*DATA_W | Page bytes, byte k in bits [8k+7:8k] |
| wp_i | input | 1 | External write-protect level |
| low_vdd_i | input | 1 | Low-supply detector flag |
| busy_o | output | 1 | Internal write cycle in progress |
| wr_valid_o | output | 1 | Write beat valid toward the array |
| wr_ready_i | input | 1 | Array accepts the beat |
| wr_addr_o | output | ADDR_W | Address of the write beat |
| wr_data_o | output | DATA_W | Data of the write beat |
| abort_o | output | 1 | One-clock pulse when a command or cycle is cancelled |
| locked_o | output | 1 | Lower-half lock flag |

## Verification
A sweep steps the base address through every page with every byte count from 1 to 16. Starting offsets inside a page vary, so a wrong wrap of the low address bits or an off-by-one busy length shows up against the arithmetic model. The protect level is then raised before the D0 strobe, between D0 and commit, and inside the programming phase. Each placement must give a different result: accepted, cancelled before start, or stopped mid-cycle. Further cases cover the low-supply flag, commits injected while busy, and an array that stalls every other beat. The lock sequence runs aborted, starved and completed, and the page sweep is repeated once the lock is set.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PROG  = 2'd1,
    ST_DRAIN = 2'd2
  } wpc_state_e;

  typedef enum logic {
    OP_DATA = 1'b0,
    OP_LOCK = 1'b1
  } wpc_op_e;
endpackage

// File: rtl/wpc_window.sv
// Tracks the protect-level sampling window that opens on D0 capture and
// closes on commit; outputs whether the pending command must be cancelled.
module wpc_window (
  input  logic clk,
  input  logic rst_n,
  input  logic idle_i,
  input  logic d0_cap_i,
  input  logic commit_i,
  input  logic wp_i,
  output logic cancel_o
);
  logic armed_q;
  logic hit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      hit_q   <= 1'b0;
    end else if (commit_i || !idle_i) begin
      armed_q <= 1'b0;
      hit_q   <= 1'b0;
    end else begin
      if (d0_cap_i) armed_q <= 1'b1;
      if (armed_q && wp_i) hit_q <= 1'b1;
    end
  end

  assign cancel_o = hit_q | (armed_q & wp_i);
endmodule

// File: rtl/wpc_timer.sv
// Programming-phase counter: counts while run_i, reports the last clock.
module wpc_timer #(
  parameter int CYC_CLKS = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic done_o
);
  localparam int TW = $clog2(CYC_CLKS + 1);
  localparam logic [TW-1:0] LAST = TW'(CYC_CLKS - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!run_i)       cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/wpc_gate.sv
// Per-slot address generation inside the page and the lower-half lock rule.
module wpc_gate #(
  parameter int ADDR_W     = 8,
  parameter int PAGE_BYTES = 16
) (
  input  logic [ADDR_W-1:0]                  base_i,
  input  logic                               locked_i,
  output logic [PAGE_BYTES-1:0][ADDR_W-1:0]  slot_addr_o,
  output logic [PAGE_BYTES-1:0]              slot_ok_o
);
  localparam int IDX_W = $clog2(PAGE_BYTES);

  for (genvar k = 0; k < PAGE_BYTES; k++) begin : g_slot
    logic [IDX_W-1:0] low;
    assign low = base_i[IDX_W-1:0] + IDX_W'(k);
    assign slot_addr_o[k] = {base_i[ADDR_W-1:IDX_W], low};
    assign slot_ok_o[k]   = slot_addr_o[k][ADDR_W-1] | ~locked_i;
  end
endmodule

// File: rtl/wp_wcycle_ctrl.sv
module wp_wcycle_ctrl #(
  parameter int   ADDR_W     = 8,
  parameter int   DATA_W     = 8,
  parameter int   PAGE_BYTES = 16,
  parameter int   CNT_W      = $clog2(PAGE_BYTES + 1),
  parameter int   WCYC_CLKS  = 5000,
  parameter logic LOCK_INIT  = 1'b0
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_start_i,
  input  logic                           d0_cap_i,
  input  logic                           lock_cmd_i,
  input  logic [ADDR_W-1:0]              page_addr_i,
  input  logic [CNT_W-1:0]               page_cnt_i,
  input  logic [PAGE_BYTES*DATA_W-1:0]   page_data_i,
  input  logic                           wp_i,
  input  logic                           low_vdd_i,
  output logic                           busy_o,
  output logic                           wr_valid_o,
  input  logic                           wr_ready_i,
  output logic [ADDR_W-1:0]              wr_addr_o,
  output logic [DATA_W-1:0]              wr_data_o,
  output logic                           abort_o,
  output logic                           locked_o
);
  import wpc_pkg::*;

  localparam int IDX_W = $clog2(PAGE_BYTES);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(PAGE_BYTES);

  wpc_state_e                   state_q;
  wpc_op_e                      op_q;
  logic [ADDR_W-1:0]            base_q;
  logic [CNT_W-1:0]             cnt_q;
  logic [PAGE_BYTES*DATA_W-1:0] data_q;
  logic [IDX_W-1:0]             idx_q;
  logic                         locked_q;
  logic                         abort_q;

  logic idle, commit, cancel, prog_done, in_drain, byte_go, advance, last;
  logic [PAGE_BYTES-1:0][ADDR_W-1:0] slot_addr;
  logic [PAGE_BYTES-1:0]             slot_ok;
  logic [CNT_W-1:0]                  idx_next;

  assign idle     = (state_q == ST_IDLE);
  assign commit   = idle & (wr_start_i | lock_cmd_i);
  assign in_drain = (state_q == ST_DRAIN);

  wpc_window u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .idle_i   (idle),
    .d0_cap_i (d0_cap_i),
    .commit_i (commit),
    .wp_i     (wp_i),
    .cancel_o (cancel)
  );

  wpc_timer #(.CYC_CLKS(WCYC_CLKS)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (state_q == ST_PROG),
    .done_o (prog_done)
  );

  wpc_gate #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_gate (
    .base_i      (base_q),
    .locked_i    (locked_q),
    .slot_addr_o (slot_addr),
    .slot_ok_o   (slot_ok)
  );

  assign byte_go  = in_drain & slot_ok[idx_q] & ~wp_i & ~low_vdd_i;
  assign advance  = in_drain & (~byte_go | wr_ready_i);
  assign idx_next = CNT_W'(idx_q) + 1'b1;
  assign last     = (idx_next >= cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      op_q     <= OP_DATA;
      base_q   <= '0;
      cnt_q    <= '0;
      data_q   <= '0;
      idx_q    <= '0;
      locked_q <= LOCK_INIT;
      abort_q  <= 1'b0;
    end else begin
      abort_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (lock_cmd_i) begin
            if (!locked_q) begin
              if (cancel) abort_q <= 1'b1;
              else begin
                state_q <= ST_PROG;
                op_q    <= OP_LOCK;
              end
            end
          end else if (wr_start_i) begin
            if (cancel) abort_q <= 1'b1;
            else begin
              state_q <= ST_PROG;
              op_q    <= OP_DATA;
              base_q  <= page_addr_i;
              cnt_q   <= (page_cnt_i > CNT_MAX) ? CNT_MAX : page_cnt_i;
              data_q  <= page_data_i;
              idx_q   <= '0;
            end
          end
        end
        ST_PROG: begin
          if (wp_i) begin
            state_q <= ST_IDLE;
            abort_q <= 1'b1;
          end else if (prog_done) begin
            if (op_q == OP_LOCK) begin
              if (!low_vdd_i) locked_q <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_DRAIN;
            end
          end
        end
        ST_DRAIN: begin
          if (wp_i) begin
            state_q <= ST_IDLE;
            abort_q <= 1'b1;
          end else if (advance) begin
            if (last) state_q <= ST_IDLE;
            else      idx_q   <= idx_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = ~idle;
  assign wr_valid_o = byte_go;
  assign wr_addr_o  = slot_addr[idx_q];
  assign wr_data_o  = data_q[idx_q*DATA_W +: DATA_W];
  assign abort_o    = abort_q;
  assign locked_o   = locked_q;
endmodule

// File: rtl/wpc_chk.sv
module wpc_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lock_cmd_i,
  input logic              wp_i,
  input logic              low_vdd_i,
  input logic              busy_o,
  input logic              wr_valid_o,
  input logic              wr_ready_i,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [DATA_W-1:0] wr_data_o,
  input logic              abort_o,
  input logic              locked_o
);
  // R3
  wp_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_i && busy_o) |=> (!busy_o && abort_o));

  // R2
  beat_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> busy_o);

  // R4
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(locked_o));

  // R4
  lower_half_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && locked_o) |-> wr_addr_o[ADDR_W-1]);

  // R7
  low_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_vdd_i |-> !wr_valid_o);

  // R5
  relock_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_o && lock_cmd_i && !busy_o) |=> (!busy_o && !abort_o));

  // R9
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && !wr_ready_i) |=>
      (wp_i || low_vdd_i ||
       (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o))));
endmodule

bind wp_wcycle_ctrl wpc_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wpc_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lock_cmd_i (lock_cmd_i),
  .wp_i       (wp_i),
  .low_vdd_i  (low_vdd_i),
  .busy_o     (busy_o),
  .wr_valid_o (wr_valid_o),
  .wr_ready_i (wr_ready_i),
  .wr_addr_o  (wr_addr_o),
  .wr_data_o  (wr_data_o),
  .abort_o    (abort_o),
  .locked_o   (locked_o)
);

// File: tb/test_wp_wcycle_ctrl.sv
module test_wp_wcycle_ctrl;
  localparam int AW = 8, DW = 8, PB = 16, CW = 5, WCYC = 12;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic wr_start = 1'b0, d0_cap = 1'b0, lock_cmd = 1'b0;
  logic [AW-1:0] page_addr = '0;
  logic [CW-1:0] page_cnt = '0;
  logic [PB*DW-1:0] page_data = '0;
  logic wp = 1'b0, low_vdd = 1'b0, wr_ready = 1'b1;
  logic busy, wr_valid, abort, locked;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  wp_wcycle_ctrl #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(PB), .CNT_W(CW),
                   .WCYC_CLKS(WCYC)) i_wp_wcycle_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_start_i(wr_start), .d0_cap_i(d0_cap),
    .lock_cmd_i(lock_cmd), .page_addr_i(page_addr), .page_cnt_i(page_cnt),
    .page_data_i(page_data), .wp_i(wp), .low_vdd_i(low_vdd), .busy_o(busy),
    .wr_valid_o(wr_valid), .wr_ready_i(wr_ready), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .abort_o(abort), .locked_o(locked));

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_mem [256];
  logic [7:0] obs_mem [256];
  bit lock_m = 1'b0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] dat(input logic [7:0] b, input int k);
    return 8'(int'(b) * 7 + k * 29 + 53);
  endfunction

  // wp_mode: 0 none, 1 high before D0 only, 2 high between D0 and commit
  task automatic run_op(input bit prot, input logic [7:0] base, input int cnt,
                        input int wp_mode, input bit lowv, input int abort_at,
                        input bit inject, input bit bp, input string req);
    int busy_n = 0;
    int aborts = 0;
    int mism = 0;
    bit accepted, aborted;
    @(negedge clk); if (wp_mode == 1) wp = 1'b1;
    @(negedge clk); if (wp_mode == 1) wp = 1'b0; d0_cap = 1'b1;
    @(negedge clk); d0_cap = 1'b0; if (wp_mode == 2) wp = 1'b1;
    @(negedge clk);
    wp = 1'b0;
    page_addr = base;
    page_cnt = CW'(cnt);
    for (int k = 0; k < PB; k++) page_data[k*DW +: DW] = dat(base, k);
    low_vdd = lowv;
    wr_ready = !bp;
    if (prot) lock_cmd = 1'b1; else wr_start = 1'b1;
    @(negedge clk);
    lock_cmd = 1'b0; wr_start = 1'b0;
    for (int g = 0; g < 4000; g++) begin
      #1;
      if (abort) aborts++;
      if (!busy) break;
      busy_n++;
      if (wr_valid && wr_ready) obs_mem[wr_addr] = wr_data;
      @(negedge clk);
      wp = (abort_at > 0) && (busy_n == abort_at);
      wr_start = inject && (busy_n == 2);
      d0_cap = inject && (busy_n == 4);
      if (inject) page_addr = base + 8'h40;
      wr_ready = bp ? busy_n[0] : 1'b1;
    end
    wp = 1'b0; wr_start = 1'b0; d0_cap = 1'b0; wr_ready = 1'b1; low_vdd = 1'b0;
    accepted = (wp_mode != 2) && !(prot && lock_m);
    aborted  = (wp_mode == 2) || (accepted && abort_at > 0);
    if (accepted && !aborted) begin
      if (prot) begin
        if (!lowv) lock_m = 1'b1;
      end else if (!lowv) begin
        for (int k = 0; k < cnt && k < PB; k++) begin
          logic [7:0] a;
          a = {base[7:4], 4'(base[3:0] + 4'(k))};
          if (a[7] || !lock_m) exp_mem[a] = dat(base, k);
        end
      end
    end
    if (!bp)
      chk(req, "busy cycles", busy_n,
          !accepted ? 0 : (abort_at > 0 ? abort_at + 1
                           : WCYC + (prot ? 0 : (cnt > PB ? PB : cnt))));
    chk(req, "abort pulses", aborts, aborted ? 1 : 0);
    for (int i = 0; i < 256; i++) if (obs_mem[i] !== exp_mem[i]) mism++;
    chk(req, "memory mismatches", mism, 0);
    chk(req, "lock flag", int'(locked), int'(lock_m));
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin exp_mem[i] = 8'hFF; obs_mem[i] = 8'hFF; end
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "busy", int'(busy), 0);
    chk("R10", "wr_valid", int'(wr_valid), 0);
    chk("R10", "abort", int'(abort), 0);
    chk("R10", "locked", int'(locked), 0);
    rst_n = 1'b1;
    // R2 R8 page sweep, every count 1..16 at varying offsets
    for (int b = 0; b < 256; b += 9)
      run_op(0, 8'(b), ((b / 9) % 16) + 1, 0, 0, 0, 0, 0, "R2_R8 sweep");
    run_op(0, 8'h3C, 20, 0, 0, 0, 0, 0, "R8 clip");
    // R1 window
    run_op(0, 8'h51, 5, 1, 0, 0, 0, 0, "R1 wp before D0");
    run_op(0, 8'h62, 5, 2, 0, 0, 0, 0, "R1 wp after D0");
    // R3 stop during programming
    run_op(0, 8'h73, 6, 0, 0, 5, 0, 0, "R3 data abort");
    // R7 low supply
    run_op(0, 8'h24, 8, 0, 1, 0, 0, 0, "R7 low supply write");
    // R6 commands while busy
    run_op(0, 8'h95, 4, 0, 0, 0, 1, 0, "R6 inject");
    // R9 back-pressure
    run_op(0, 8'hA7, 16, 0, 0, 0, 0, 1, "R9 stall");
    // lock sequence
    run_op(1, 8'h00, 1, 0, 0, 3, 0, 0, "R3 lock abort");
    run_op(1, 8'h00, 1, 0, 1, 0, 0, 0, "R7 lock low supply");
    run_op(1, 8'h00, 1, 0, 0, 0, 0, 0, "R4 lock");
    for (int b = 3; b < 256; b += 21)
      run_op(0, 8'(b), (b % 16) + 1, 0, 0, 0, 0, 0, "R4 locked sweep");
    run_op(1, 8'h00, 1, 0, 0, 0, 0, 0, "R5 relock");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule